// File: doc/BRIEF.md
# Card I/O Guard-Time and Framing Monitor

This block sits beside the character engine of a smart-card interface and watches the single I/O line shared by host and card. Each time the start-bit detector reports a falling edge of a new character, the monitor starts two measurements in parallel. One times the guard window that must pass before the other side may begin the next character. The other samples the line a quarter of an ETU after the end of the tenth bit, where a correctly framed character must have released the line high.

All timing comes from a quarter-ETU tick supplied from outside. The guard window is 22 ETUs, which is 88 quarter ticks. The framing sample falls at 10.25 ETUs, which is the 41st quarter tick. The guard flag is a live indication: a start bit clears it and the elapsed window sets it. The framing flag is sticky and is cleared by the status-register read strobe. Neither flag drives an interrupt. The surrounding interface uses the guard flag to spot a card that answers too early, or a host that transmits too soon after a received character.

Top module: `card_guard_monitor`

## Requirements
- R1: While reset is high, and in the cycle after it, both `guard_ok` and `frame_err` are 0.
- R2: After a start bit, `guard_ok` becomes 1 in the cycle after the 88th `qtr_tick` (22 ETU × 4) that follows the start bit.
- R3: A `start_bit` pulse clears `guard_ok` in the next cycle and restarts the 88-tick count. A start bit before the count ends keeps `guard_ok` low.
- R4: On the 41st `qtr_tick` after a start bit, `io_level` is sampled. A value of 0 sets `frame_err` in the next cycle. A value of 1 leaves it unchanged.
- R5: `frame_err` stays at 1 until `status_rd` is pulsed. A `status_rd` pulse with no new error clears it in the next cycle.
- R6: If `status_rd` and a new framing error fall in the same cycle, `frame_err` is 1 afterwards.
- R7: The line is sampled only once per start bit. A start bit inside the framing window restarts the 41-tick count, and a low line after the sample point does not set `frame_err`.
- R8: A `qtr_tick` in the same cycle as `start_bit` is not counted by either measurement.
- R9: Once set, `guard_ok` stays at 1 until the next start bit, whatever `status_rd` and `io_level` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_bit | input | 1 | One-cycle strobe: a start bit was detected on the I/O line (either direction) |
| qtr_tick | input | 1 | One-cycle strobe every quarter ETU |
| io_level | input | 1 | Synchronised I/O line level (1 = released high) |
| status_rd | input | 1 | One-cycle strobe: the status register is being read |
| guard_ok | output | 1 | Guard time of 22 ETU has elapsed since the last start bit |
| frame_err | output | 1 | Sticky framing error: line was low at the 10.25 ETU sample point |

## Verification
The assertions check on every cycle the behaviours that can be stated locally. A start bit always clears the guard flag. The guard flag only rises after the guard window timer expires and holds until a start bit. The framing flag only rises from a low sample at the expiry of the framing window, holds until a read, and is cleared by a read that has no competing error. The exact tick counts can only be shown by the bench's scenarios, by checking one tick before and one tick after each boundary. The same applies to the restart of a window by an early start bit, the ignored tick in the start cycle, the single sample per character, and the read that collides with an error.

// File: rtl/cgm_pkg.sv
package cgm_pkg;

    // Quarter ticks that make up one elementary time unit
    localparam int unsigned QTR_PER_ETU = 4;

    // Default guard window in ETUs
    localparam int unsigned GUARD_ETU_DEF = 22;

    // Default framing sample point in quarter ticks (10.25 ETU)
    localparam int unsigned FRAME_QTR_DEF = 41;

    // Window timer state
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    // Flags reported by the monitor
    typedef struct packed {
        logic guard_ok;
        logic frame_err;
    } cgm_flags_t;

    // Convert an ETU count into quarter ticks
    function automatic int unsigned etu_to_qtr(input int unsigned etu);
        return etu * QTR_PER_ETU;
    endfunction

endpackage

// File: rtl/cgm_window_timer.sv
module cgm_window_timer
    import cgm_pkg::*;
#(
    parameter int unsigned LIMIT = 88
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    tmr_state_e    state;
    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);
    // The expiring tick is the LIMIT-th tick counted after the restart
    assign expire  = (state == TMR_RUN) && tick && !restart && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TMR_IDLE;
            cnt   <= '0;
        end else if (restart) begin
            // A tick in the restart cycle is deliberately not counted
            state <= TMR_RUN;
            cnt   <= '0;
        end else if (state == TMR_RUN && tick) begin
            if (at_last) begin
                state <= TMR_IDLE;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cgm_guard_flag.sv
module cgm_guard_flag (
    input  logic clk,
    input  logic rst,
    input  logic start_bit,
    input  logic window_done,
    output logic guard_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            guard_ok <= 1'b0;
        end else if (start_bit) begin
            guard_ok <= 1'b0;
        end else if (window_done) begin
            guard_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/cgm_frame_check.sv
module cgm_frame_check (
    input  logic clk,
    input  logic rst,
    input  logic sample_now,
    input  logic io_level,
    input  logic status_rd,
    output logic frame_err
);
    logic bad_frame;

    // The line must be released high at the sample point
    assign bad_frame = sample_now && !io_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_err <= 1'b0;
        end else if (bad_frame) begin
            // A new error takes priority over a clearing read
            frame_err <= 1'b1;
        end else if (status_rd) begin
            frame_err <= 1'b0;
        end
    end
endmodule

// File: rtl/card_guard_monitor.sv
module card_guard_monitor
    import cgm_pkg::*;
#(
    parameter int unsigned GUARD_ETU = GUARD_ETU_DEF,
    parameter int unsigned FRAME_QTR = FRAME_QTR_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic start_bit,
    input  logic qtr_tick,
    input  logic io_level,
    input  logic status_rd,
    output logic guard_ok,
    output logic frame_err
);
    localparam int unsigned GUARD_QTR = etu_to_qtr(GUARD_ETU);

    logic       guard_expire;
    logic       frame_expire;
    cgm_flags_t flags;

    cgm_window_timer #(.LIMIT(GUARD_QTR)) u_guard_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (start_bit),
        .tick    (qtr_tick),
        .expire  (guard_expire)
    );

    cgm_window_timer #(.LIMIT(FRAME_QTR)) u_frame_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (start_bit),
        .tick    (qtr_tick),
        .expire  (frame_expire)
    );

    cgm_guard_flag u_guard (
        .clk         (clk),
        .rst         (rst),
        .start_bit   (start_bit),
        .window_done (guard_expire),
        .guard_ok    (flags.guard_ok)
    );

    cgm_frame_check u_frame (
        .clk        (clk),
        .rst        (rst),
        .sample_now (frame_expire),
        .io_level   (io_level),
        .status_rd  (status_rd),
        .frame_err  (flags.frame_err)
    );

    assign guard_ok  = flags.guard_ok;
    assign frame_err = flags.frame_err;
endmodule

// File: rtl/card_guard_monitor_chk.sv
module card_guard_monitor_chk (
    input logic clk,
    input logic rst,
    input logic start_bit,
    input logic io_level,
    input logic status_rd,
    input logic guard_ok,
    input logic frame_err,
    input logic guard_expire,
    input logic frame_expire
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!guard_ok && !frame_err));

    // R3
    start_clears_guard_chk: assert property (@(posedge clk) disable iff (rst)
        start_bit |=> !guard_ok);

    // R2
    guard_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(guard_ok) |-> $past(guard_expire));

    // R9
    guard_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (guard_ok && !start_bit) |=> guard_ok);

    // R4
    frame_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> $past(frame_expire && !io_level));

    // R5
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_err && !status_rd) |=> frame_err);

    // R5
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !frame_expire) |=> !frame_err);

    // R6
    frame_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_expire && !io_level && status_rd) |=> frame_err);
endmodule

bind card_guard_monitor card_guard_monitor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_bit    (start_bit),
    .io_level     (io_level),
    .status_rd    (status_rd),
    .guard_ok     (guard_ok),
    .frame_err    (frame_err),
    .guard_expire (guard_expire),
    .frame_expire (frame_expire)
);

// File: tb/card_guard_monitor_test.sv
module card_guard_monitor_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_bit = 1'b0;
    logic qtr_tick = 1'b0;
    logic io_level = 1'b1;
    logic status_rd = 1'b0;
    logic guard_ok;
    logic frame_err;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    card_guard_monitor uut (
        .clk       (clk),
        .rst       (rst),
        .start_bit (start_bit),
        .qtr_tick  (qtr_tick),
        .io_level  (io_level),
        .status_rd (status_rd),
        .guard_ok  (guard_ok),
        .frame_err (frame_err)
    );

    always #10 clk = ~clk;

    // Behavioural reference: elapsed quarter ticks since the last start bit
    int  m_gq = 0;
    int  m_fq = 0;
    bit  m_grun = 0;
    bit  m_frun = 0;
    bit  m_bgt = 0;
    bit  m_fer = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_gq = 0; m_fq = 0; m_grun = 0; m_frun = 0; m_bgt = 0; m_fer = 0;
        end else if (start_bit) begin
            m_gq = 0; m_fq = 0; m_grun = 1; m_frun = 1; m_bgt = 0;
            if (status_rd) m_fer = 0;
        end else begin
            bit err_now;
            err_now = 0;
            if (qtr_tick && m_grun) begin
                m_gq++;
                if (m_gq == 88) begin m_bgt = 1; m_grun = 0; end
            end
            if (qtr_tick && m_frun) begin
                m_fq++;
                if (m_fq == 41) begin
                    m_frun = 0;
                    if (!io_level) err_now = 1;
                end
            end
            if (err_now) m_fer = 1;
            else if (status_rd) m_fer = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            check(guard_ok == m_bgt, "R2", "guard_ok vs model", guard_ok, m_bgt);
            check(frame_err == m_fer, "R4", "frame_err vs model", frame_err, m_fer);
        end
    end

    // Drive one cycle of inputs; return at the following falling edge
    task automatic step(input bit sb, input bit qt, input bit io, input bit rd);
        start_bit = sb; qtr_tick = qt; io_level = io; status_rd = rd;
        @(negedge clk);
        start_bit = 0; qtr_tick = 0; status_rd = 0;
    endtask

    // n quarter ticks, each followed by one idle cycle
    task automatic ticks(input int n, input bit io);
        for (int i = 0; i < n; i++) begin
            step(0, 1, io, 0);
            step(0, 0, io, 0);
        end
    endtask

    task automatic report;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "WATCHDOG", "run did not finish", cycles, 0);
        report();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1
        check(guard_ok == 0 && frame_err == 0, "R1", "flags in reset",
              {guard_ok, frame_err}, 0);
        rst = 0;
        @(negedge clk);
        check(guard_ok == 0 && frame_err == 0, "R1", "flags after reset",
              {guard_ok, frame_err}, 0);

        // R2: boundary at 87 and 88 ticks
        step(1, 0, 1, 0);
        ticks(87, 1);
        check(guard_ok == 0, "R2", "guard after 87 ticks", guard_ok, 0);
        step(0, 1, 1, 0);
        check(guard_ok == 1, "R2", "guard after 88 ticks", guard_ok, 1);

        // R9: read and line activity leave guard_ok alone
        step(0, 0, 0, 1);
        ticks(5, 0);
        check(guard_ok == 1, "R9", "guard held after read", guard_ok, 1);

        // R3: start clears guard, early start keeps it low
        step(1, 0, 1, 0);
        check(guard_ok == 0, "R3", "guard cleared by start", guard_ok, 0);
        ticks(50, 1);
        step(1, 0, 1, 0);
        ticks(87, 1);
        check(guard_ok == 0, "R3", "guard low after restart", guard_ok, 0);
        ticks(1, 1);
        check(guard_ok == 1, "R3", "guard after restarted window", guard_ok, 1);

        // R8: tick in the start cycle is ignored
        step(1, 1, 1, 0);
        ticks(87, 1);
        check(guard_ok == 0, "R8", "start-cycle tick not counted", guard_ok, 0);
        ticks(1, 1);
        check(guard_ok == 1, "R8", "guard at 88 counted ticks", guard_ok, 1);

        // R4: line high at sample point, no error
        step(1, 0, 1, 0);
        ticks(41, 1);
        check(frame_err == 0, "R4", "released line no error", frame_err, 0);

        // R4: line low exactly at 41st tick
        step(1, 0, 1, 0);
        ticks(40, 1);
        step(0, 1, 0, 0);
        check(frame_err == 1, "R4", "low line at 10.25 ETU", frame_err, 1);

        // R5: holds without read, clears on read
        ticks(3, 1);
        check(frame_err == 1, "R5", "error held", frame_err, 1);
        step(0, 0, 1, 1);
        check(frame_err == 0, "R5", "error cleared by read", frame_err, 0);

        // R7: only one sample per start bit
        ticks(10, 0);
        check(frame_err == 0, "R7", "no resample after window", frame_err, 0);

        // R7: restart inside the window moves the sample point
        step(1, 0, 1, 0);
        ticks(30, 1);
        step(1, 0, 1, 0);
        ticks(10, 1);
        step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        check(frame_err == 0, "R7", "old sample point ignored", frame_err, 0);
        ticks(29, 1);
        step(0, 1, 0, 0);
        check(frame_err == 1, "R7", "new sample point", frame_err, 1);
        step(0, 0, 1, 1);
        check(frame_err == 0, "R5", "cleared before R6 case", frame_err, 0);

        // R6: read colliding with a new error
        step(1, 0, 1, 0);
        ticks(40, 1);
        step(0, 1, 0, 1);
        check(frame_err == 1, "R6", "error wins over read", frame_err, 1);
        step(0, 0, 1, 1);
        check(frame_err == 0, "R6", "later read clears", frame_err, 0);

        repeat (3) @(negedge clk);
        report();
    end
endmodule